// File: doc/BRIEF.md
# Page Referenced/Changed Bit Updater

This block sits beside the data-side translation buffer and decides, for every access that hit in it, whether the page's referenced (R) and changed (C) status bits must be recorded. A fixed priority order of scenarios settles the decision. A no-execute violation is checked first, then a page-protection violation, then speculative (out-of-order) execution, and finally the class of the access. When the hit entry already holds every bit the scenario asks for, the block does nothing. Otherwise it asks the page-table walker for the page table entry (PTE) and receives the PTE word. It writes the word back with the new bits ORed in, as one read-modify-write. It then reloads the translation entry with the bits that were written.

Several store-class operations set C even though they write no memory. These are a conditional store with no reservation, a string store of zero length, and a store that a later exception prevents. Cache touch hints can only ever set R. The write-back always carries fixed memory attributes: not guarded, cacheable, coherent, and with data translation off. While a sequence runs, the block holds `busy` high and ignores new accesses.

Top module: `rc_updater`

## Requirements
- R1: `acc_op` codes are 0 load, 1 instruction fetch, 2 store, 3 conditional store, 4 string store, 5 touch, 6 touch-for-store. A permitted store-class access (codes 2 to 4) whose hit entry already has C=1 starts no walk, and `busy` stays low.
- R2: A permitted store-class access with hit-entry C=0 performs exactly one PTE write, with both R and C set. It then performs one TLB reload with R=1 and C=1.
- R3: A permitted conditional store sets C whether or not `acc_resv` is high.
- R4: A permitted string store sets C when `acc_zero_len` is high.
- R5: A permitted store sets C when `acc_exc` reports an exception taken before the store.
- R6: Touch operations (codes 5 and 6) set R when the hit entry has R=0. They never set C, and a C bit already present in the PTE is preserved.
- R7: With `acc_nx_viol` high, no update is made for any operation. This takes highest priority.
- R8: With `acc_prot_viol` high and no no-execute violation, only R is set, and only if the hit entry has R=0. This holds for stores too, including a conditional store without a reservation.
- R9: With `acc_ooo` high and neither violation present, no update is made.
- R10: A permitted load or fetch sets R when the hit entry has R=0. When R=1 it makes no update.
- R11: During the PTE write, `wb_guarded`=0, `wb_cacheable`=1, `wb_coherent`=1 and `wb_xlate_en`=0.
- R12: The sequence runs in this order: walk request until grant, read data, write held until ready with stable data, a one-cycle TLB reload, then back to idle. `busy` is high throughout, and accesses presented while busy are ignored.
- R13: R sits at PTE bit 8 and C at PTE bit 7. Every other PTE bit is written back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_op | input | 3 | Access class code |
| acc_vpn | input | VPN_W | Page number of the access |
| acc_nx_viol | input | 1 | No-execute violation |
| acc_prot_viol | input | 1 | Page-protection violation |
| acc_ooo | input | 1 | Access is speculative, out of order |
| acc_resv | input | 1 | Reservation held (conditional store) |
| acc_exc | input | 1 | Exception taken before the store |
| acc_zero_len | input | 1 | String store length is zero |
| tlb_hit_r | input | 1 | R bit of the hit entry |
| tlb_hit_c | input | 1 | C bit of the hit entry |
| busy | output | 1 | Update sequence in progress |
| walk_req | output | 1 | PTE fetch request to the walker |
| walk_vpn | output | VPN_W | Page under update, for both fetch and write |
| walk_gnt | input | 1 | Walker accepted the request |
| walk_rvalid | input | 1 | PTE read data valid |
| walk_rdata | input | PTE_W | PTE read data |
| pte_wr_valid | output | 1 | PTE write-back valid |
| pte_wr_ready | input | 1 | PTE write-back accepted |
| pte_wr_data | output | PTE_W | Updated PTE word |
| wb_guarded | output | 1 | Write-back guarded attribute |
| wb_cacheable | output | 1 | Write-back cacheable attribute |
| wb_coherent | output | 1 | Write-back coherence-required attribute |
| wb_xlate_en | output | 1 | Data translation state used for write-back |
| tlb_ld_valid | output | 1 | TLB entry reload pulse |
| tlb_ld_vpn | output | VPN_W | Page of the reloaded entry |
| tlb_ld_r | output | 1 | Reloaded R bit |
| tlb_ld_c | output | 1 | Reloaded C bit |

## Verification
Each access class is tried with the hit entry's bits clear and then already set. This separates real updates from correctly skipped ones and shows that C, not R, gates stores. Stores are repeated with no reservation, zero length and a prior exception to show that a store needs no actual write to set C. The violation and speculation flags are then stacked on the same store to show which scenario wins. PTE images with all other bits set, or with C already present, show that the merge only ever adds bits. A stalled write with a competing access during the stall shows the hold and ignore behaviour.

// File: rtl/rc_upd_pkg.sv
// Shared types for the referenced/changed bit updater.
// Assumes the access code encoding below is shared with the load/store unit.
package rc_upd_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_FETCH    = 3'd1,
        OP_STORE    = 3'd2,
        OP_STCOND   = 3'd3,
        OP_STSTRING = 3'd4,
        OP_TOUCH    = 3'd5,
        OP_TOUCH_ST = 3'd6,
        OP_RSVD     = 3'd7
    } acc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WALK_REQ,
        S_WAIT_WALK,
        S_WRITE_PTE,
        S_RELOAD_TLB,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic set_r;
        logic set_c;
    } rc_need_t;

    // Attributes of every PTE write-back: plain coherent cacheable, translation off.
    localparam logic WB_GUARDED   = 1'b0;
    localparam logic WB_CACHEABLE = 1'b1;
    localparam logic WB_COHERENT  = 1'b1;
    localparam logic WB_XLATE_EN  = 1'b0;

    function automatic logic is_store_class(acc_op_e op);
        return (op == OP_STORE) || (op == OP_STCOND) || (op == OP_STSTRING);
    endfunction

    function automatic logic is_touch(acc_op_e op);
        return (op == OP_TOUCH) || (op == OP_TOUCH_ST);
    endfunction

endpackage

// File: rtl/rc_upd_classify.sv
// Scenario classifier: applies the prioritized rule set to one access and
// reports which status bits it needs and whether the hit entry lacks them.
// Assumes the access hit in the TLB. Reservation, exception and zero-length
// qualifiers deliberately do not influence the decision.
module rc_upd_classify
    import rc_upd_pkg::*;
(
    input  logic [2:0] op,
    input  logic       nx_viol,
    input  logic       prot_viol,
    input  logic       ooo,
    input  logic       resv,
    input  logic       exc,
    input  logic       zero_len,
    input  logic       tlb_r,
    input  logic       tlb_c,
    output rc_need_t   need,
    output logic       upd
);

    acc_op_e op_e;
    assign op_e = acc_op_e'(op);

    // Walk the scenarios from highest to lowest priority.
    always_comb begin : decide_bits
        need = '0;
        if (nx_viol) begin
            need = '0;
        end else if (prot_viol) begin
            need.set_r = 1'b1;
        end else if (ooo) begin
            need = '0;
        end else if (is_store_class(op_e)) begin
            need.set_r = 1'b1;
            need.set_c = 1'b1;
        end else if (op_e != OP_RSVD) begin
            need.set_r = 1'b1;
        end
    end

    // Stores are gated by C alone; everything else by R.
    always_comb begin : decide_update
        if (need.set_c) upd = !tlb_c;
        else            upd = need.set_r && !tlb_r;
    end

    // Rule checks on the classifier outputs.
    always_comb begin : rule_checks
        if (is_touch(op_e)) begin
            assert_touch_never_c_R6: assert (!need.set_c)
                else $error("touch requested C");
        end
        if (nx_viol) begin
            assert_nx_no_update_R7: assert (!upd)
                else $error("update despite no-execute violation");
        end
        if (is_store_class(op_e) && !nx_viol && !prot_viol && !ooo && !tlb_c
            && (!resv || exc || zero_len)) begin
            assert_c_without_write_R3: assert (upd && need.set_c)
                else $error("non-writing permitted store did not set C");
        end
    end

endmodule

// File: rtl/rc_upd_merge.sv
// PTE merge: ORs the requested status bits into a fetched PTE image.
// Assumes R_BIT and C_BIT are distinct positions inside the word.
module rc_upd_merge
    import rc_upd_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int R_BIT = 8,
    parameter int C_BIT = 7
) (
    input  logic [PTE_W-1:0] rd_pte,
    input  rc_need_t         need,
    output logic [PTE_W-1:0] wr_pte,
    output logic             new_r,
    output logic             new_c
);

    // Per-bit merge: only the two status positions can change, and only upward.
    for (genvar i = 0; i < PTE_W; i++) begin : g_bit
        if (i == R_BIT) begin : g_r
            assign wr_pte[i] = rd_pte[i] | need.set_r;
        end else if (i == C_BIT) begin : g_c
            assign wr_pte[i] = rd_pte[i] | need.set_c;
        end else begin : g_keep
            assign wr_pte[i] = rd_pte[i];
        end
    end

    assign new_r = wr_pte[R_BIT];
    assign new_c = wr_pte[C_BIT];

endmodule

// File: rtl/rc_upd_seq.sv
// Update sequencer: walk request, read, write-back, TLB reload, done.
// Assumes the walker holds read data for one cycle with walk_rvalid and the
// write port may stall with ready low for any number of cycles.
module rc_upd_seq
    import rc_upd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic walk_gnt,
    input  logic walk_rvalid,
    input  logic wr_ready,
    output logic busy,
    output logic walk_req,
    output logic cap_req,
    output logic cap_rd,
    output logic wr_valid,
    output logic ld_valid
);

    seq_state_e state_q, state_d;

    // Next-state selection for the update sequence.
    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start)       state_d = S_WALK_REQ;
            S_WALK_REQ:   if (walk_gnt)    state_d = S_WAIT_WALK;
            S_WAIT_WALK:  if (walk_rvalid) state_d = S_WRITE_PTE;
            S_WRITE_PTE:  if (wr_ready)    state_d = S_RELOAD_TLB;
            S_RELOAD_TLB:                  state_d = S_DONE;
            S_DONE:                        state_d = S_IDLE;
            default:                       state_d = S_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs and capture strobes.
    always_comb begin : decode_out
        busy     = (state_q != S_IDLE);
        walk_req = (state_q == S_WALK_REQ);
        wr_valid = (state_q == S_WRITE_PTE);
        ld_valid = (state_q == S_RELOAD_TLB);
        cap_req  = (state_q == S_IDLE) && start;
        cap_rd   = (state_q == S_WAIT_WALK) && walk_rvalid;
    end

    assert_wr_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid)
        else $error("write dropped before ready");

    assert_ld_after_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(wr_valid && wr_ready))
        else $error("reload without completed write");

    assert_ld_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid)
        else $error("reload longer than one cycle");

    assert_req_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_gnt |=> !walk_req)
        else $error("walk request held after grant");

endmodule

// File: rtl/rc_updater.sv
// Referenced/changed bit updater top. Classifies each TLB-hit access, and
// when the hit entry lacks a required bit, performs one read-modify-write of
// the PTE through the walker followed by a TLB reload.
// Assumes acc_valid is only raised for accesses that hit in the TLB; accesses
// arriving while busy are dropped by design.
module rc_updater
    import rc_upd_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PTE_W = 32,
    parameter int R_BIT = 8,
    parameter int C_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [2:0]       acc_op,
    input  logic [VPN_W-1:0] acc_vpn,
    input  logic             acc_nx_viol,
    input  logic             acc_prot_viol,
    input  logic             acc_ooo,
    input  logic             acc_resv,
    input  logic             acc_exc,
    input  logic             acc_zero_len,
    input  logic             tlb_hit_r,
    input  logic             tlb_hit_c,
    output logic             busy,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_gnt,
    input  logic             walk_rvalid,
    input  logic [PTE_W-1:0] walk_rdata,
    output logic             pte_wr_valid,
    input  logic             pte_wr_ready,
    output logic [PTE_W-1:0] pte_wr_data,
    output logic             wb_guarded,
    output logic             wb_cacheable,
    output logic             wb_coherent,
    output logic             wb_xlate_en,
    output logic             tlb_ld_valid,
    output logic [VPN_W-1:0] tlb_ld_vpn,
    output logic             tlb_ld_r,
    output logic             tlb_ld_c
);

    rc_need_t         need;
    rc_need_t         need_q;
    logic             upd;
    logic             cap_req;
    logic             cap_rd;
    logic [VPN_W-1:0] vpn_q;
    logic [PTE_W-1:0] rd_q;
    logic [PTE_W-1:0] merged;
    logic             new_r;
    logic             new_c;

    rc_upd_classify u_classify (
        .op        (acc_op),
        .nx_viol   (acc_nx_viol),
        .prot_viol (acc_prot_viol),
        .ooo       (acc_ooo),
        .resv      (acc_resv),
        .exc       (acc_exc),
        .zero_len  (acc_zero_len),
        .tlb_r     (tlb_hit_r),
        .tlb_c     (tlb_hit_c),
        .need      (need),
        .upd       (upd)
    );

    rc_upd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (acc_valid && upd),
        .walk_gnt    (walk_gnt),
        .walk_rvalid (walk_rvalid),
        .wr_ready    (pte_wr_ready),
        .busy        (busy),
        .walk_req    (walk_req),
        .cap_req     (cap_req),
        .cap_rd      (cap_rd),
        .wr_valid    (pte_wr_valid),
        .ld_valid    (tlb_ld_valid)
    );

    rc_upd_merge #(
        .PTE_W (PTE_W),
        .R_BIT (R_BIT),
        .C_BIT (C_BIT)
    ) u_merge (
        .rd_pte (rd_q),
        .need   (need_q),
        .wr_pte (merged),
        .new_r  (new_r),
        .new_c  (new_c)
    );

    // Latch the accepted access and, later, the fetched PTE image.
    always_ff @(posedge clk) begin : capture_regs
        if (!rst_n) begin
            vpn_q  <= '0;
            need_q <= '0;
            rd_q   <= '0;
        end else begin
            if (cap_req) begin
                vpn_q  <= acc_vpn;
                need_q <= need;
            end
            if (cap_rd) begin
                rd_q <= walk_rdata;
            end
        end
    end

    assign walk_vpn     = vpn_q;
    assign tlb_ld_vpn   = vpn_q;
    assign pte_wr_data  = merged;
    assign tlb_ld_r     = new_r;
    assign tlb_ld_c     = new_c;
    assign wb_guarded   = WB_GUARDED;
    assign wb_cacheable = WB_CACHEABLE;
    assign wb_coherent  = WB_COHERENT;
    assign wb_xlate_en  = WB_XLATE_EN;

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && acc_valid |=> $stable(walk_vpn))
        else $error("access accepted while busy");

    assert_wr_data_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pte_wr_valid && !pte_wr_ready |=> $stable(pte_wr_data))
        else $error("write data changed while stalled");

    assert_keep_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pte_wr_valid |-> ((pte_wr_data & rd_q) == rd_q))
        else $error("write-back cleared a PTE bit");

    assert_reload_has_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_ld_valid |-> tlb_ld_r)
        else $error("reload without R");

endmodule

// File: tb/rc_updater_tb.sv
module rc_updater_tb;

    localparam int VPN_W = 20;
    localparam int PTE_W = 32;
    localparam int RB    = 8;
    localparam int CB    = 7;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PTE_W-1:0] pte;
        logic             r;
        logic             c;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [2:0]       acc_op = '0;
    logic [VPN_W-1:0] acc_vpn = '0;
    logic             acc_nx_viol = 1'b0;
    logic             acc_prot_viol = 1'b0;
    logic             acc_ooo = 1'b0;
    logic             acc_resv = 1'b0;
    logic             acc_exc = 1'b0;
    logic             acc_zero_len = 1'b0;
    logic             tlb_hit_r = 1'b0;
    logic             tlb_hit_c = 1'b0;
    logic             busy;
    logic             walk_req;
    logic [VPN_W-1:0] walk_vpn;
    logic             walk_gnt = 1'b0;
    logic             walk_rvalid = 1'b0;
    logic [PTE_W-1:0] walk_rdata = '0;
    logic             pte_wr_valid;
    logic             pte_wr_ready = 1'b1;
    logic [PTE_W-1:0] pte_wr_data;
    logic             wb_guarded, wb_cacheable, wb_coherent, wb_xlate_en;
    logic             tlb_ld_valid;
    logic [VPN_W-1:0] tlb_ld_vpn;
    logic             tlb_ld_r, tlb_ld_c;

    logic [PTE_W-1:0] mem_pte = '0;
    exp_t             sb_q[$];
    int               drv_checks = 0, drv_fails = 0;
    int               mon_checks = 0, mon_fails = 0;
    int               cyc = 0;

    always #2 clk = ~clk;

    rc_updater #(.VPN_W(VPN_W), .PTE_W(PTE_W), .R_BIT(RB), .C_BIT(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
        .acc_vpn(acc_vpn), .acc_nx_viol(acc_nx_viol), .acc_prot_viol(acc_prot_viol),
        .acc_ooo(acc_ooo), .acc_resv(acc_resv), .acc_exc(acc_exc),
        .acc_zero_len(acc_zero_len), .tlb_hit_r(tlb_hit_r), .tlb_hit_c(tlb_hit_c),
        .busy(busy), .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_gnt(walk_gnt),
        .walk_rvalid(walk_rvalid), .walk_rdata(walk_rdata),
        .pte_wr_valid(pte_wr_valid), .pte_wr_ready(pte_wr_ready),
        .pte_wr_data(pte_wr_data), .wb_guarded(wb_guarded),
        .wb_cacheable(wb_cacheable), .wb_coherent(wb_coherent),
        .wb_xlate_en(wb_xlate_en), .tlb_ld_valid(tlb_ld_valid),
        .tlb_ld_vpn(tlb_ld_vpn), .tlb_ld_r(tlb_ld_r), .tlb_ld_c(tlb_ld_c)
    );

    // Walker model: one-cycle grant, read data on the following cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            walk_gnt    <= 1'b0;
            walk_rvalid <= 1'b0;
        end else begin
            walk_gnt    <= walk_req && !walk_gnt;
            walk_rvalid <= walk_req && walk_gnt;
            walk_rdata  <= mem_pte;
        end
    end

    // Scoreboard monitor: compares write-backs and reloads with queued items.
    always @(negedge clk) begin
        if (rst_n && pte_wr_valid && pte_wr_ready) begin
            mon_checks++;
            if (sb_q.size() == 0) begin
                mon_fails++;
                $display("FAIL R12 unexpected PTE write actual=%h expected=none", pte_wr_data);
            end else if (pte_wr_data !== sb_q[0].pte || walk_vpn !== sb_q[0].vpn) begin
                mon_fails++;
                $display("FAIL R13 PTE write actual=%h/%h expected=%h/%h",
                         pte_wr_data, walk_vpn, sb_q[0].pte, sb_q[0].vpn);
            end
            mon_checks++;
            if ({wb_guarded, wb_cacheable, wb_coherent, wb_xlate_en} !== 4'b0110) begin
                mon_fails++;
                $display("FAIL R11 attributes actual=%b expected=0110",
                         {wb_guarded, wb_cacheable, wb_coherent, wb_xlate_en});
            end
        end
        if (rst_n && tlb_ld_valid) begin
            mon_checks++;
            if (sb_q.size() == 0) begin
                mon_fails++;
                $display("FAIL R12 unexpected reload actual=%h expected=none", tlb_ld_vpn);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (tlb_ld_vpn !== e.vpn || tlb_ld_r !== e.r || tlb_ld_c !== e.c) begin
                    mon_fails++;
                    $display("FAIL R2 reload actual=%h r%b c%b expected=%h r%b c%b",
                             tlb_ld_vpn, tlb_ld_r, tlb_ld_c, e.vpn, e.r, e.c);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("%0d/%0d checks passed",
                     drv_checks + mon_checks - drv_fails - mon_fails,
                     drv_checks + mon_checks + 1);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        drv_checks++;
        if (!ok) begin
            drv_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Reference rules taken from the requirement list.
    task automatic model(input logic [2:0] op, input logic nx, input logic prot,
                         input logic ooo, input logic tr, input logic tc,
                         output logic r, output logic c, output logic u);
        r = 1'b0;
        c = 1'b0;
        if (nx) begin
        end else if (prot) begin
            r = 1'b1;
        end else if (ooo) begin
        end else if (op == 3'd2 || op == 3'd3 || op == 3'd4) begin
            r = 1'b1;
            c = 1'b1;
        end else if (op != 3'd7) begin
            r = 1'b1;
        end
        u = c ? !tc : (r && !tr);
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 40 && busy; i++) tick();
        chk(!busy, tag, "return to idle", {31'd0, busy}, 32'd0);
        chk(sb_q.size() == 0, tag, "all expected results seen", sb_q.size(), 32'd0);
    endtask

    task automatic present(input logic [2:0] op, input logic nx, input logic prot,
                           input logic ooo, input logic resv, input logic exc,
                           input logic zl, input logic tr, input logic tc,
                           input logic [VPN_W-1:0] vpn);
        acc_op = op; acc_nx_viol = nx; acc_prot_viol = prot; acc_ooo = ooo;
        acc_resv = resv; acc_exc = exc; acc_zero_len = zl;
        tlb_hit_r = tr; tlb_hit_c = tc; acc_vpn = vpn; acc_valid = 1'b1;
    endtask

    // Driver: pushes the expected result, presents the access, waits it out.
    task automatic run(input string tag, input logic [2:0] op, input logic nx,
                       input logic prot, input logic ooo, input logic resv,
                       input logic exc, input logic zl, input logic tr,
                       input logic tc, input logic [VPN_W-1:0] vpn,
                       input logic [PTE_W-1:0] pte);
        logic r, c, u;
        exp_t e;
        model(op, nx, prot, ooo, tr, tc, r, c, u);
        mem_pte = pte;
        if (u) begin
            e.vpn = vpn;
            e.pte = pte | (PTE_W'(r) << RB) | (PTE_W'(c) << CB);
            e.r   = e.pte[RB];
            e.c   = e.pte[CB];
            sb_q.push_back(e);
        end
        present(op, nx, prot, ooo, resv, exc, zl, tr, tc, vpn);
        tick();
        acc_valid = 1'b0;
        if (u) begin
            chk(busy === 1'b1, tag, "busy after accept", {31'd0, busy}, 32'd1);
            wait_idle(tag);
        end else begin
            chk(busy === 1'b0 && walk_req === 1'b0, tag, "no update started",
                {30'd0, busy, walk_req}, 32'd0);
            tick();
            chk(busy === 1'b0, tag, "still idle", {31'd0, busy}, 32'd0);
        end
        tick();
    endtask

    initial begin
        exp_t e;
        for (int i = 0; i < 3; i++) tick();
        // Reset state
        chk(!busy && !walk_req && !pte_wr_valid && !tlb_ld_valid, "R12", "reset outputs",
            {28'd0, busy, walk_req, pte_wr_valid, tlb_ld_valid}, 32'd0);
        rst_n = 1'b1;
        tick();

        // R10: load and fetch
        run("R10", 3'd0, 0,0,0,0,0,0, 0,0, 20'h00011, 32'h1234_0000);
        run("R10", 3'd1, 0,0,0,0,0,0, 1,0, 20'h00012, 32'h0000_0100);
        run("R10", 3'd1, 0,0,0,0,0,0, 0,0, 20'h00013, 32'h0000_0000);
        // R2 / R1: plain store
        run("R2",  3'd2, 0,0,0,0,0,0, 1,0, 20'h00021, 32'hA5A5_0100);
        run("R2",  3'd2, 0,0,0,0,0,0, 0,0, 20'h00022, 32'h0000_0000);
        run("R1",  3'd2, 0,0,0,0,0,0, 0,1, 20'h00023, 32'h0000_0000);
        run("R1",  3'd4, 0,0,0,0,0,0, 1,1, 20'h00024, 32'h0000_0000);
        // R3, R4, R5: stores that write nothing still set C
        run("R3",  3'd3, 0,0,0,0,0,0, 1,0, 20'h00031, 32'h0000_0100);
        run("R3",  3'd3, 0,0,0,1,0,0, 1,0, 20'h00032, 32'h0000_0100);
        run("R4",  3'd4, 0,0,0,0,0,1, 1,0, 20'h00041, 32'h0000_0100);
        run("R5",  3'd2, 0,0,0,0,1,0, 1,0, 20'h00051, 32'h0000_0100);
        // R6: touch operations
        run("R6",  3'd5, 0,0,0,0,0,0, 0,0, 20'h00061, 32'h0000_0000);
        run("R6",  3'd6, 0,0,0,0,0,0, 0,0, 20'h00062, 32'h0000_0080);
        run("R6",  3'd6, 0,0,0,0,0,0, 1,0, 20'h00063, 32'h0000_0000);
        // R7: no-execute beats everything
        run("R7",  3'd2, 1,1,0,0,0,0, 0,0, 20'h00071, 32'h0000_0000);
        run("R7",  3'd1, 1,0,0,0,0,0, 0,0, 20'h00072, 32'h0000_0000);
        // R8: protection violation sets R only
        run("R8",  3'd3, 0,1,0,0,0,0, 0,0, 20'h00081, 32'h0000_0000);
        run("R8",  3'd2, 0,1,1,0,0,0, 0,0, 20'h00082, 32'h0000_0000);
        run("R8",  3'd2, 0,1,0,0,0,0, 1,0, 20'h00083, 32'h0000_0000);
        // R9: speculative accesses record nothing
        run("R9",  3'd0, 0,0,1,0,0,0, 0,0, 20'h00091, 32'h0000_0000);
        run("R9",  3'd2, 0,0,1,0,0,0, 0,0, 20'h00092, 32'h0000_0000);
        // R13: other PTE bits survive
        run("R13", 3'd0, 0,0,0,0,0,0, 0,0, 20'hFFFFF, 32'hFFFF_FE7F);
        run("R13", 3'd2, 0,0,0,0,0,0, 0,0, 20'h5A5A5, 32'h8000_0001);

        // R12: stalled write, plus an access presented while busy
        mem_pte = 32'h0F00_0000;
        e.vpn = 20'h000C1;
        e.pte = 32'h0F00_0180;
        e.r = 1'b1;
        e.c = 1'b1;
        sb_q.push_back(e);
        pte_wr_ready = 1'b0;
        present(3'd2, 0,0,0,0,0,0, 0,0, 20'h000C1);
        tick();
        acc_valid = 1'b0;
        for (int i = 0; i < 20 && !pte_wr_valid; i++) tick();
        chk(pte_wr_valid === 1'b1, "R12", "write reached", {31'd0, pte_wr_valid}, 32'd1);
        present(3'd0, 0,0,0,0,0,0, 0,0, 20'h000C2);
        tick();
        acc_valid = 1'b0;
        chk(pte_wr_valid === 1'b1 && pte_wr_data === 32'h0F00_0180, "R12", "write held",
            pte_wr_data, 32'h0F00_0180);
        chk(walk_vpn === 20'h000C1, "R12", "busy access ignored",
            {12'd0, walk_vpn}, 32'h000C1);
        tick();
        chk(pte_wr_valid === 1'b1, "R12", "write still held", {31'd0, pte_wr_valid}, 32'd1);
        pte_wr_ready = 1'b1;
        wait_idle("R12");
        tick();
        chk(!busy && !walk_req, "R12", "ignored access left no work",
            {30'd0, busy, walk_req}, 32'd0);

        $display("%0d/%0d checks passed",
                 drv_checks + mon_checks - drv_fails - mon_fails,
                 drv_checks + mon_checks);
        $finish;
    end

endmodule